// File: doc/BRIEF.md
# Scan-Chain Debug Message Port

This block gives a debug host access to a register file through an ordinary boundary-scan TAP. It holds the instruction register and every data register reached through the scan path. A state machine outside the block supplies the decoded TAP states. The host first loads an arming instruction. It then selects either the inbound or the outbound message register with a second instruction. Each selected register is reached by a normal data-register scan.

An inbound message is 47 bits long. It carries a 6-bit transfer code, a direction flag, a register index and a 32-bit payload. The block decodes the message when the data register is updated. It then writes the register file, or reads it into a result holder. The outbound register loads a 6-bit status code and 32 data bits from that result holder on capture, and the host shifts it out on the next scan. The message layout starts with the transfer code, as it does on the other debug ports, so the protocol does not change over the scan path.

All state runs on TCK. The reset input is asynchronous and active low, and its release is synchronised to TCK.

Top module: `jtag_msg_client`

## Requirements
- R1: While reset is applied and after it is released, TDO shows the bypass bit (0), no register-file write occurs, and the result holder reads status 0x00 with data 0.
- R2: The instruction register is IR_LEN bits (default 4) and is shifted LSB first. Capture loads the value 1. The shifted value becomes the current instruction on update_ir.
- R3: Opcode 0xC arms the block. Opcodes 0xD (inbound) and 0xE (outbound) select the message registers only while the block is armed. These two opcodes keep the armed state. Any other opcode disarms the block. Under any unselected instruction the data path is a 1-bit bypass register that captures 0.
- R4: The inbound message is shifted LSB first with bits [5:0] = transfer code, [6] = write flag (1 = write), [14:7] = register index and [46:15] = data. Capture clears the whole inbound register to zero.
- R5: A message with transfer code 0x1C, the write flag set and an index below NUM_REGS drives rf_we with rf_addr and rf_wdata in the first cycle of update_dr. The result becomes status 0x22 with the written data.
- R6: A message with code 0x1C, the write flag clear and an index in range sets the result to status 0x21 with the register's value at update time. No write occurs.
- R7: An index at or above NUM_REGS gives status 0x3F with data 0 and no write. Index NUM_REGS-1 is still accepted.
- R8: A transfer code other than 0x1C gives status 0x3E with data 0 and no register-file access.
- R9: The outbound register loads {data, status} on capture_dr and shifts it out LSB first, so the 6 status bits come out first and the 32 data bits follow.
- R10: When the block is not armed, scans of the message registers go through the bypass bit and rf_we never rises.
- R11: rf_we is high for exactly one TCK cycle per update, even when update_dr is held for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| tdo | output | 1 | Serial data out |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | IDX_W | Register-file index |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_rdata | input | DATA_W | Register-file read data for rf_addr |

## Verification
The bench builds the block with NUM_REGS set to 12 and leaves IR_LEN, IDX_W and DATA_W at their defaults. With 12 registers the last legal index (11) and the first rejected one (12) are both reachable with short messages, and the 8-bit index field still spans well past the limit. The defaults keep the 47-bit inbound and 38-bit outbound scans at their full length, so every field boundary is crossed during shifting.

// File: rtl/jmc_pkg.sv
package jmc_pkg;
  localparam int TC_W = 6;
  localparam logic [TC_W-1:0] TC_ACCESS = 6'h1C;

  typedef enum logic [TC_W-1:0] {
    ST_NONE    = 6'h00,
    ST_RD_OK   = 6'h21,
    ST_WR_OK   = 6'h22,
    ST_BAD_TC  = 6'h3E,
    ST_BAD_IDX = 6'h3F
  } status_e;
endpackage

// File: rtl/jmc_ir.sv
module jmc_ir #(
  parameter int IR_LEN = 4,
  parameter logic [IR_LEN-1:0] OP_ENABLE  = 4'hC,
  parameter logic [IR_LEN-1:0] OP_MSG_IN  = 4'hD,
  parameter logic [IR_LEN-1:0] OP_MSG_OUT = 4'hE
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  output logic ir_so,
  output logic sel_in,
  output logic sel_out,
  output logic armed
);
  logic [IR_LEN-1:0] sr_q, sr_d, cur_q, cur_d;
  logic              arm_q, arm_d;
  logic              keeps_arm;

  always_comb begin
    sr_d = sr_q;
    if (capture_ir)    sr_d = IR_LEN'(1);
    else if (shift_ir) sr_d = {tdi, sr_q[IR_LEN-1:1]};

    keeps_arm = (sr_q == OP_MSG_IN) || (sr_q == OP_MSG_OUT);
    cur_d = cur_q;
    arm_d = arm_q;
    if (update_ir) begin
      cur_d = sr_q;
      arm_d = (sr_q == OP_ENABLE) || (arm_q && keeps_arm);
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cur_q <= '1;
      arm_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cur_q <= cur_d;
      arm_q <= arm_d;
    end
  end

  assign ir_so   = sr_q[0];
  assign armed   = arm_q;
  assign sel_in  = arm_q && (cur_q == OP_MSG_IN);
  assign sel_out = arm_q && (cur_q == OP_MSG_OUT);
endmodule

// File: rtl/jmc_msg_in.sv
module jmc_msg_in
  import jmc_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              so,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [TC_W-1:0]   res_code,
  output logic [DATA_W-1:0] res_data
);
  localparam int MSG_W   = TC_W + 1 + IDX_W + DATA_W;
  localparam int WR_POS  = TC_W;
  localparam int IDX_POS = TC_W + 1;
  localparam int DAT_POS = IDX_POS + IDX_W;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic [MSG_W-1:0]  sr_q, sr_d;
  logic              upd_q;
  logic [TC_W-1:0]   code_q, code_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic [TC_W-1:0]   f_tc;
  logic              f_wr;
  logic [IDX_W-1:0]  f_idx;
  logic [DATA_W-1:0] f_dat;
  logic              tc_ok, idx_ok, upd_edge;

  assign f_tc  = sr_q[TC_W-1:0];
  assign f_wr  = sr_q[WR_POS];
  assign f_idx = sr_q[IDX_POS +: IDX_W];
  assign f_dat = sr_q[DAT_POS +: DATA_W];

  assign tc_ok    = (f_tc == TC_ACCESS);
  assign idx_ok   = ({1'b0, f_idx} < LIMIT);
  assign upd_edge = sel && update_dr && !upd_q;

  always_comb begin
    sr_d = sr_q;
    if (sel && capture_dr)    sr_d = '0;
    else if (sel && shift_dr) sr_d = {tdi, sr_q[MSG_W-1:1]};

    code_d = code_q;
    data_d = data_q;
    if (upd_edge) begin
      if (!tc_ok) begin
        code_d = ST_BAD_TC;
        data_d = '0;
      end else if (!idx_ok) begin
        code_d = ST_BAD_IDX;
        data_d = '0;
      end else if (f_wr) begin
        code_d = ST_WR_OK;
        data_d = f_dat;
      end else begin
        code_d = ST_RD_OK;
        data_d = rf_rdata;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      upd_q  <= 1'b0;
      code_q <= ST_NONE;
      data_q <= '0;
    end else begin
      sr_q   <= sr_d;
      upd_q  <= update_dr;
      code_q <= code_d;
      data_q <= data_d;
    end
  end

  assign so       = sr_q[0];
  assign rf_we    = upd_edge && tc_ok && idx_ok && f_wr;
  assign rf_addr  = f_idx;
  assign rf_wdata = f_dat;
  assign res_code = code_q;
  assign res_data = data_q;
endmodule

// File: rtl/jmc_msg_out.sv
module jmc_msg_out
  import jmc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic [TC_W-1:0]   res_code,
  input  logic [DATA_W-1:0] res_data,
  output logic              so
);
  localparam int OUT_W = TC_W + DATA_W;

  logic [OUT_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (sel && capture_dr)    sr_d = {res_data, res_code};
    else if (sel && shift_dr) sr_d = {tdi, sr_q[OUT_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign so = sr_q[0];
endmodule

// File: rtl/jtag_msg_client.sv
module jtag_msg_client
  import jmc_pkg::*;
#(
  parameter int IR_LEN   = 4,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter logic [IR_LEN-1:0] OP_ENABLE  = 4'hC,
  parameter logic [IR_LEN-1:0] OP_MSG_IN  = 4'hD,
  parameter logic [IR_LEN-1:0] OP_MSG_OUT = 4'hE
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              capture_ir,
  input  logic              shift_ir,
  input  logic              update_ir,
  output logic              tdo,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              byp_q, byp_d;
  logic              ir_so, in_so, out_so;
  logic              sel_in, sel_out, armed;
  logic [TC_W-1:0]   res_code;
  logic [DATA_W-1:0] res_data;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    byp_d = byp_q;
    if (capture_dr)    byp_d = 1'b0;
    else if (shift_dr) byp_d = tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  jmc_ir #(
    .IR_LEN(IR_LEN), .OP_ENABLE(OP_ENABLE),
    .OP_MSG_IN(OP_MSG_IN), .OP_MSG_OUT(OP_MSG_OUT)
  ) u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .ir_so(ir_so), .sel_in(sel_in), .sel_out(sel_out), .armed(armed)
  );

  jmc_msg_in #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_in (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .sel(sel_in),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .rf_rdata(rf_rdata), .so(in_so), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .res_code(res_code), .res_data(res_data)
  );

  jmc_msg_out #(
    .DATA_W(DATA_W)
  ) u_out (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .sel(sel_out),
    .capture_dr(capture_dr), .shift_dr(shift_dr),
    .res_code(res_code), .res_data(res_data), .so(out_so)
  );

  always_comb begin
    if (shift_ir)     tdo = ir_so;
    else if (sel_in)  tdo = in_so;
    else if (sel_out) tdo = out_so;
    else              tdo = byp_q;
  end
endmodule

// File: rtl/jmc_chk.sv
module jmc_chk #(
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input logic              tck,
  input logic              rst_n,
  input logic              update_dr,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_addr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              armed,
  input logic [5:0]        res_code,
  input logic [DATA_W-1:0] res_data
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  assert_we_pulse_R11: assert property (@(posedge tck) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_we_in_range_R7: assert property (@(posedge tck) disable iff (!rst_n)
    rf_we |-> ({1'b0, rf_addr} < LIMIT));

  assert_we_needs_arm_R10: assert property (@(posedge tck) disable iff (!rst_n)
    rf_we |-> armed);

  assert_we_on_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
    rf_we |-> update_dr);

  assert_write_status_R5: assert property (@(posedge tck) disable iff (!rst_n)
    rf_we |=> (res_code == 6'h22) && (res_data == $past(rf_wdata)));
endmodule

bind jtag_msg_client jmc_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .tck(tck), .rst_n(rst_n), .update_dr(update_dr), .rf_we(rf_we),
  .rf_addr(rf_addr), .rf_wdata(rf_wdata), .armed(armed),
  .res_code(res_code), .res_data(res_data)
);

// File: tb/tb_jtag_msg_client.sv
module tb_jtag_msg_client;
  localparam int NREG = 12;

  logic        tck = 1'b0;
  logic        trst_n, tdi, capture_dr, shift_dr, update_dr;
  logic        capture_ir, shift_ir, update_ir;
  logic        tdo, rf_we;
  logic [7:0]  rf_addr;
  logic [31:0] rf_wdata, rf_rdata;
  logic [31:0] rf_mem [0:255];

  always #5 tck = ~tck;

  jtag_msg_client #(.NUM_REGS(NREG)) dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .tdo(tdo), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // bench-side register file
  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge tck) begin
    if (!trst_n) begin
      for (int i = 0; i < 256; i++) rf_mem[i] <= 32'hA500_0000 + i;
    end else if (rf_we) begin
      rf_mem[rf_addr] <= rf_wdata;
    end
  end

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [3:0]  m_ir_sr, m_ir;
  bit          m_armed, m_byp, m_upd_q;
  logic [46:0] m_in;
  logic [37:0] m_out;
  logic [5:0]  m_code;
  logic [31:0] m_data;
  logic [31:0] m_regs [0:255];

  task automatic fail(string r, string what, logic [63:0] got, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s got %h exp %h", r, what, got, exp);
  endtask

  task automatic chk(string r, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) fail(r, what, got, exp);
  endtask

  task automatic step(bit cdr, bit sdr, bit udr, bit cir, bit sir, bit uir,
                      bit din, output bit seen);
    bit s_in, s_out, fire, tcok, idxok, exp_we, exp_tdo, wr;
    logic [7:0]  idx;
    logic [31:0] pay;
    @(negedge tck);
    capture_dr = cdr; shift_dr = sdr; update_dr = udr;
    capture_ir = cir; shift_ir = sir; update_ir = uir; tdi = din;
    #2;
    s_in  = m_armed && (m_ir == 4'hD);
    s_out = m_armed && (m_ir == 4'hE);
    idx   = m_in[14:7];
    pay   = m_in[46:15];
    wr    = m_in[6];
    tcok  = (m_in[5:0] == 6'h1C);
    idxok = (idx < NREG);
    fire  = s_in && udr && !m_upd_q;
    exp_we = fire && tcok && idxok && wr;
    exp_tdo = sir ? m_ir_sr[0] : s_in ? m_in[0] : s_out ? m_out[0] : m_byp;
    seen = tdo;
    chk(cur_req, "tdo", 64'(tdo), 64'(exp_tdo));
    chk("R11", "rf_we", 64'(rf_we), 64'(exp_we));
    if (exp_we) chk("R5", "addr/data", {24'h0, rf_addr, rf_wdata}, {24'h0, idx, pay});
    @(posedge tck);
    #1;
    if (uir) begin
      m_armed = (m_ir_sr == 4'hC) || (m_armed && (m_ir_sr == 4'hD || m_ir_sr == 4'hE));
      m_ir = m_ir_sr;
    end
    if (cir) m_ir_sr = 4'h1;
    else if (sir) m_ir_sr = {din, m_ir_sr[3:1]};
    if (s_in) begin
      if (cdr) m_in = '0;
      else if (sdr) m_in = {din, m_in[46:1]};
    end
    if (s_out) begin
      if (cdr) m_out = {m_data, m_code};
      else if (sdr) m_out = {din, m_out[37:1]};
    end
    if (cdr) m_byp = 1'b0;
    else if (sdr) m_byp = din;
    if (fire) begin
      if (!tcok) begin m_code = 6'h3E; m_data = 0; end
      else if (!idxok) begin m_code = 6'h3F; m_data = 0; end
      else if (wr) begin m_code = 6'h22; m_data = pay; m_regs[idx] = pay; end
      else begin m_code = 6'h21; m_data = m_regs[idx]; end
    end
    m_upd_q = udr;
  endtask

  task automatic load_ir(logic [3:0] op, output logic [3:0] cap);
    bit s;
    step(0,0,0,1,0,0,0,s);
    for (int i = 0; i < 4; i++) begin
      step(0,0,0,0,1,0,op[i],s);
      cap[i] = s;
    end
    step(0,0,0,0,0,1,0,s);
    step(0,0,0,0,0,0,0,s);
  endtask

  task automatic scan_dr(logic [63:0] din, int n, int upd, output logic [63:0] dout);
    bit s;
    dout = '0;
    step(1,0,0,0,0,0,0,s);
    for (int i = 0; i < n; i++) begin
      step(0,1,0,0,0,0,din[i],s);
      dout[i] = s;
    end
    for (int i = 0; i < upd; i++) step(0,0,1,0,0,0,0,s);
    step(0,0,0,0,0,0,0,s);
  endtask

  function automatic logic [63:0] msg(logic [5:0] tc, bit wr, logic [7:0] idx, logic [31:0] d);
    return {17'h0, d, idx, wr, tc};
  endfunction

  task automatic send(logic [63:0] m, int upd);
    logic [3:0]  c;
    logic [63:0] o;
    load_ir(4'hD, c);
    scan_dr(m, 47, upd, o);
  endtask

  task automatic expect_out(string r, logic [5:0] code, logic [31:0] d);
    logic [3:0]  c;
    logic [63:0] o;
    load_ir(4'hE, c);
    scan_dr(64'h0, 38, 1, o);
    chk(r, "reply", o, {26'h0, d, code});
  endtask

  initial begin
    logic [3:0]  cap;
    logic [63:0] o, m;
    trst_n = 0; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
    capture_ir = 0; shift_ir = 0; update_ir = 0;
    m_ir_sr = 0; m_ir = 4'hF; m_armed = 0; m_byp = 0; m_upd_q = 0;
    m_in = 0; m_out = 0; m_code = 0; m_data = 0;
    for (int i = 0; i < 256; i++) m_regs[i] = 32'hA500_0000 + i;
    repeat (3) @(negedge tck);
    #2;
    chk("R1", "tdo in reset", 64'(tdo), 64'h0);
    chk("R1", "rf_we in reset", 64'(rf_we), 64'h0);
    trst_n = 1;
    repeat (4) @(negedge tck);

    // R2: capture value shifted out of the IR
    cur_req = "R2";
    load_ir(4'h5, cap);
    chk("R2", "ir capture", 64'(cap), 64'h1);

    // R10: selecting the inbound register without arming -> bypass
    cur_req = "R10";
    m = msg(6'h1C, 1, 8'd2, 32'h1111_2222);
    load_ir(4'hD, cap);
    scan_dr(m, 47, 1, o);
    chk("R10", "bypass path", o, (m << 1) & ((64'd1 << 47) - 1));

    // R1: arm, empty reply after reset
    cur_req = "R1";
    load_ir(4'hC, cap);
    expect_out("R1", 6'h00, 32'h0);

    // R4: capture clears inbound register
    cur_req = "R4";
    load_ir(4'hD, cap);
    scan_dr(64'h0, 47, 0, o);
    chk("R4", "cleared inbound", o, 64'h0);

    // R5 / R9: write then reply
    cur_req = "R5";
    send(msg(6'h1C, 1, 8'd3, 32'hDEAD_BEEF), 1);
    expect_out("R9", 6'h22, 32'hDEAD_BEEF);

    // R6: read back the written register and an untouched one (R10)
    cur_req = "R6";
    send(msg(6'h1C, 0, 8'd3, 32'h0), 1);
    expect_out("R6", 6'h21, 32'hDEAD_BEEF);
    send(msg(6'h1C, 0, 8'd2, 32'h0), 1);
    expect_out("R10", 6'h21, 32'hA500_0002);

    // R7: last legal index, then first illegal one
    cur_req = "R7";
    send(msg(6'h1C, 1, 8'd11, 32'h0BAD_F00D), 1);
    expect_out("R7", 6'h22, 32'h0BAD_F00D);
    send(msg(6'h1C, 1, 8'd12, 32'h1234_5678), 1);
    expect_out("R7", 6'h3F, 32'h0);
    send(msg(6'h1C, 0, 8'd200, 32'h0), 1);
    expect_out("R7", 6'h3F, 32'h0);

    // R8: unknown transfer code
    cur_req = "R8";
    send(msg(6'h1D, 1, 8'd4, 32'hFFFF_0000), 1);
    expect_out("R8", 6'h3E, 32'h0);
    send(msg(6'h1C, 0, 8'd4, 32'h0), 1);
    expect_out("R8", 6'h21, 32'hA500_0004);

    // R11: update held three cycles -> single strobe
    cur_req = "R11";
    send(msg(6'h1C, 1, 8'd5, 32'hCAFE_0005), 3);
    send(msg(6'h1C, 0, 8'd5, 32'h0), 1);
    expect_out("R11", 6'h21, 32'hCAFE_0005);

    // R3: another opcode disarms; bypass returns
    cur_req = "R3";
    load_ir(4'h3, cap);
    m = msg(6'h1C, 1, 8'd6, 32'h5555_AAAA);
    load_ir(4'hD, cap);
    scan_dr(m, 47, 1, o);
    chk("R3", "disarmed bypass", o, (m << 1) & ((64'd1 << 47) - 1));
    load_ir(4'hC, cap);
    send(msg(6'h1C, 0, 8'd6, 32'h0), 1);
    expect_out("R3", 6'h21, 32'hA500_0006);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule